// File: doc/BRIEF.md
# UART Modem Handshake Control and Status

This block is the modem-side register pair of a serial port. It keeps a small control register whose bits drive the outgoing handshake pins: request-to-send, terminal-ready and two general-purpose outputs. It also builds a status byte from four incoming handshake lines: clear-to-send, data-set-ready, ring and carrier detect. The incoming lines first pass through a two-flop synchroniser. Every change is then latched into a sticky change bit that stays set until the host reads the status byte. An OR of the change bits is exported as a flag for the interrupt controller.

A self-test mode is selected by a bit of the control register. In that mode the control bits are fed back internally onto the status lines with a fixed cross-mapping. The external status inputs are ignored, and the request-to-send and terminal-ready pins are held inactive.

The mode is held by a two-state machine. `ST_LINE` is normal operation and `ST_LOOP` is self-test. The transition `enter_loop` (ST_LINE to ST_LOOP) is taken on a control write with bit 4 set. The transition `leave_loop` (ST_LOOP to ST_LINE) is taken on a control write with bit 4 clear. Host access uses one register select line: `sel`=0 is the control register and `sel`=1 is the status register. Read data is combinational. A status read with `rd_en` high returns the value before the clear, and the change bits are cleared at the next clock edge.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register reads 0x08 (only OUT2 set) and the status register reads 0xB0 (carrier, data-set-ready and clear-to-send high, ring low, no change bits). The flag is low, `out2_o` is 1, and `rts_o`, `dtr_o` and `out1_o` are 0.
- R2: A control write stores data bits 3:0 (bit 0 terminal-ready, bit 1 request-to-send, bit 2 OUT1, bit 3 OUT2) and bit 4 (self-test). A control read returns these five bits, with bits 7:5 reading 0.
- R3: In ST_LINE, `dtr_o`, `rts_o`, `out1_o` and `out2_o` equal control bits 0, 1, 2 and 3, active high, from the edge that stores the write. `out1_o` and `out2_o` follow their bits in both states.
- R4: In ST_LOOP, `rts_o` and `dtr_o` are 0 whatever the control bits hold.
- R5: Status bits 7:4 show carrier, ring, data-set-ready and clear-to-send. An external input change is not visible after two clock edges and is visible after the third.
- R6: A change in either direction of clear-to-send, data-set-ready or carrier sets status bit 0, 1 or 3 respectively.
- R7: The ring change bit (bit 2) is set only when ring goes from 1 to 0. A rise of ring leaves it clear.
- R8: Change bits accumulate and stay set until a status read.
- R9: A status read returns the byte before clearing and clears all four change bits at the next edge. A line change that is detected at that same edge still sets its bit.
- R10: `msc_flag_o` is high exactly when at least one change bit is set.
- R11: In ST_LOOP the status upper nibble takes terminal-ready as data-set-ready, request-to-send as clear-to-send, OUT1 as ring and OUT2 as carrier. It updates one edge after the control write, and the change bits follow the same rules as in ST_LINE.
- R12: In ST_LOOP the external status inputs have no effect on the status register. On `leave_loop` the synchronised external levels take over at the next edge, and the differences set change bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (side effect on status read) |
| sel | input | 1 | Register select: 0 control, 1 status |
| wr_data | input | DW | Host write data |
| rd_data | output | DW | Host read data, combinational |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| ri_i | input | 1 | Ring line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| rts_o | output | 1 | Request-to-send pin |
| dtr_o | output | 1 | Terminal-ready pin |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| msc_flag_o | output | 1 | Modem status change flag |

## Verification
A corrupted current-line register shows in the status byte, and it also shows as spurious change bits and a raised flag on the edge after the corruption. A wrong change bit reaches `msc_flag_o` in the same cycle. A wrong mode state shows at once on `rts_o`/`dtr_o`, and one edge later in the status nibble because the loopback source is selected wrongly. Because the change bits are sticky, a single false detection stays visible until the next status read. One wrong edge is therefore enough for a later read to expose it.

// File: rtl/modem_pkg.sv
package modem_pkg;

    // Status nibble layout: bit3 carrier, bit2 ring, bit1 data-set-ready, bit0 clear-to-send
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    // Control nibble layout: bit3 OUT2, bit2 OUT1, bit1 request-to-send, bit0 terminal-ready
    typedef struct packed {
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    typedef enum logic {
        ST_LINE = 1'b0,
        ST_LOOP = 1'b1
    } mode_e;

    localparam logic SEL_CTL  = 1'b0;
    localparam logic SEL_STAT = 1'b1;

    localparam int NIB      = $bits(line_t);
    localparam int LOOP_BIT = NIB;

    localparam line_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam ctl_t  CTL_RST  = '{out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};

    // Self-test cross-mapping of control bits onto status lines
    function automatic line_t loop_map(input ctl_t c);
        line_t l;
        l.dcd = c.out2;
        l.ri  = c.out1;
        l.dsr = c.dtr;
        l.cts = c.rts;
        return l;
    endfunction

endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] ff;
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= RST_VAL;
                else        ff <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff <= RST_VAL;
                else        ff <= g_stage[s-1].ff;
            end
        end
    end

    assign q = g_stage[STAGES-1].ff;

endmodule

// File: rtl/modem_ctl_fsm.sv
module modem_ctl_fsm
    import modem_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          sel,
    input  logic [DW-1:0] wr_data,
    output ctl_t          ctl_q,
    output mode_e         mode_q
);

    logic  ctl_wr;
    mode_e mode_d;

    assign ctl_wr = wr_en && (sel == SEL_CTL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_LINE;
        else        mode_q <= mode_d;
    end

    // Transitions: enter_loop, leave_loop
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_LINE: if (ctl_wr && wr_data[LOOP_BIT])  mode_d = ST_LOOP;
            ST_LOOP: if (ctl_wr && !wr_data[LOOP_BIT]) mode_d = ST_LINE;
            default: mode_d = ST_LINE;
        endcase
    end

    // Control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= CTL_RST;
        else if (ctl_wr) ctl_q <= ctl_t'(wr_data[NIB-1:0]);
    end

endmodule

// File: rtl/modem_delta.sv
module modem_delta
    import modem_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t src,
    input  logic  clr,
    output line_t cur_q,
    output line_t delta_q
);

    line_t chg;

    always_comb begin
        chg    = cur_q ^ src;
        chg.ri = cur_q.ri & ~src.ri;  // trailing edge only
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= LINE_RST;
            delta_q <= '0;
        end else begin
            cur_q   <= src;
            delta_q <= (clr ? line_t'('0) : delta_q) | chg;
        end
    end

endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import modem_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          cts_i,
    input  logic          dsr_i,
    input  logic          ri_i,
    input  logic          dcd_i,
    output logic          rts_o,
    output logic          dtr_o,
    output logic          out1_o,
    output logic          out2_o,
    output logic          msc_flag_o
);

    ctl_t  ctl_q;
    mode_e mode_q;
    line_t ext_raw, ext_sync, src, cur_q, delta_q;
    logic  stat_rd;
    logic  loop_active;

    modem_ctl_fsm #(.DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .ctl_q   (ctl_q),
        .mode_q  (mode_q)
    );

    assign ext_raw = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

    modem_sync #(
        .WIDTH   (NIB),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_raw),
        .q     (ext_sync)
    );

    // Status source selection per mode
    always_comb begin
        unique case (mode_q)
            ST_LOOP: src = loop_map(ctl_q);
            default: src = ext_sync;
        endcase
    end

    assign stat_rd = rd_en && (sel == SEL_STAT);

    modem_delta u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src),
        .clr     (stat_rd),
        .cur_q   (cur_q),
        .delta_q (delta_q)
    );

    // Pin outputs per mode
    always_comb begin
        out1_o = ctl_q.out1;
        out2_o = ctl_q.out2;
        unique case (mode_q)
            ST_LOOP: begin
                rts_o = 1'b0;
                dtr_o = 1'b0;
            end
            default: begin
                rts_o = ctl_q.rts;
                dtr_o = ctl_q.dtr;
            end
        endcase
    end

    assign loop_active = (mode_q == ST_LOOP);
    assign msc_flag_o  = |delta_q;

    always_comb begin
        rd_data = '0;
        if (sel == SEL_STAT) rd_data[2*NIB-1:0] = {cur_q, delta_q};
        else                 rd_data[NIB:0]     = {loop_active, ctl_q};
    end

endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk
    import modem_pkg::*;
#(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          sel,
    input logic [DW-1:0] rd_data,
    input logic          rts_o,
    input logic          dtr_o,
    input logic          msc_flag_o,
    input logic          loop_active,
    input logic [3:0]    cur_q,
    input logic [3:0]    delta_q
);

    AST_LOOP_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> (!rts_o && !dtr_o)); // R4

    AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CTL) |-> (rd_data[DW-1:NIB+1] == '0)); // R2

    AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && sel == SEL_STAT) |=> ((delta_q & $past(delta_q)) == $past(delta_q))); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_STAT) |=> ((cur_q != $past(cur_q)) || (delta_q == 4'b0))); // R9

    AST_RING_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cur_q[2]) && !$past(delta_q[2])) |-> !delta_q[2]); // R7

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msc_flag_o) |-> (cur_q != $past(cur_q))); // R10

endmodule

bind uart_modem_ctl uart_modem_ctl_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .sel         (sel),
    .rd_data     (rd_data),
    .rts_o       (rts_o),
    .dtr_o       (dtr_o),
    .msc_flag_o  (msc_flag_o),
    .loop_active (loop_active),
    .cur_q       (cur_q),
    .delta_q     (delta_q)
);

// File: tb/uart_modem_ctl_test.sv
module uart_modem_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cts_i = 1'b1, dsr_i = 1'b1, ri_i = 1'b0, dcd_i = 1'b1;
    logic       rts_o, dtr_o, out1_o, out2_o, msc_flag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_modem_ctl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .sel        (sel),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .cts_i      (cts_i),
        .dsr_i      (dsr_i),
        .ri_i       (ri_i),
        .dcd_i      (dcd_i),
        .rts_o      (rts_o),
        .dtr_o      (dtr_o),
        .out1_o     (out1_o),
        .out2_o     (out2_o),
        .msc_flag_o (msc_flag_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic peek(input logic s, output logic [7:0] v);
        sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic host_rd(input logic s, output logic [7:0] v);
        sel   = s;
        rd_en = 1'b1;
        #1;
        v = rd_data;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic host_wr(input logic [7:0] d);
        sel     = 1'b0;
        wr_data = d;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; sel = 1'b0;
        cts_i = 1'b1; dsr_i = 1'b1; ri_i = 1'b0; dcd_i = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        peek(1'b0, v); check("R1 ctl", v, 8'h08);
        peek(1'b1, v); check("R1 stat", v, 8'hB0);
        check("R1 pins", {4'b0, msc_flag_o, out2_o, rts_o, dtr_o}, 8'h04);
    endtask

    task automatic t_ctl_write();
        logic [7:0] v;
        do_reset();
        host_wr(8'hE6);
        peek(1'b0, v); check("R2 ctl masked", v, 8'h06);
        check("R3 pins 0x06", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h06);
        host_wr(8'h09);
        check("R3 pins 0x09", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h09);
        peek(1'b1, v); check("R3 stat untouched", v, 8'hB0);
    endtask

    task automatic t_latency();
        logic [7:0] v;
        do_reset();
        dcd_i = 1'b0;
        tick(); tick();
        peek(1'b1, v); check("R5 not yet", v, 8'hB0);
        tick();
        peek(1'b1, v); check("R5 R6 dcd", v, 8'h38);
        check("R10 flag", {7'b0, msc_flag_o}, 8'h01);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        do_reset();
        ri_i = 1'b1; repeat (3) tick();
        peek(1'b1, v); check("R7 rise", v, 8'hF0);
        check("R7 R10 no flag", {7'b0, msc_flag_o}, 8'h00);
        ri_i = 1'b0; repeat (3) tick();
        peek(1'b1, v); check("R7 fall", v, 8'hB4);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        do_reset();
        cts_i = 1'b0; repeat (3) tick();
        dsr_i = 1'b0; repeat (3) tick();
        cts_i = 1'b1; repeat (3) tick();
        peek(1'b1, v); check("R6 R8 accumulate", v, 8'h93);
        host_rd(1'b1, v); check("R9 read value", v, 8'h93);
        peek(1'b1, v); check("R9 cleared", v, 8'h90);
        check("R10 flag low", {7'b0, msc_flag_o}, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        do_reset();
        dsr_i = 1'b0; repeat (3) tick();
        peek(1'b1, v); check("R6 dsr", v, 8'h92);
        cts_i = 1'b0; tick(); tick();
        host_rd(1'b1, v); check("R9 pre-edge", v, 8'h92);
        peek(1'b1, v); check("R9 new change kept", v, 8'h81);
    endtask

    task automatic t_loop();
        logic [7:0] v;
        do_reset();
        host_wr(8'h1F);
        check("R4 pins", {4'b0, out2_o, out1_o, rts_o, dtr_o}, 8'h0C);
        tick();
        peek(1'b1, v); check("R11 all", v, 8'hF0);
        host_wr(8'h11);
        peek(1'b0, v); check("R2 loop bit", v, 8'h11);
        tick();
        peek(1'b1, v); check("R11 map", v, 8'h2D);
        cts_i = 1'b0; dsr_i = 1'b0; repeat (4) tick();
        peek(1'b1, v); check("R12 ignore", v, 8'h2D);
        host_wr(8'h03);
        check("R3 leave pins", {6'b0, rts_o, dtr_o}, 8'h03);
        tick();
        peek(1'b1, v); check("R12 leave", v, 8'h8F);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ctl_write();
        t_latency();
        t_ring();
        t_sticky();
        t_same_cycle();
        t_loop();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule